// File: doc/BRIEF.md
# Programmable Skew Clock Output Bank

This block is a digital model of four clock output banks, each driving two identical outputs. It is clocked by a fast tick clock whose period is one timing unit (tU). A reference clock arrives on `ref_i` and is sampled on every tick. One reference period spans 32, 16 or 8 tU, depending on the frequency-select input. A shared timebase locks a phase counter to the chosen edge of the reference. Each bank forms its outputs from that phase: it shifts the reference by a whole number of tU, or it divides or inverts the reference.

Each bank has two three-level select inputs, `sel_hi_i` and `sel_lo_i`. Together they give nine settings, and each bank kind maps them to its own table of offsets or modes. A positive offset makes the output lag the reference. A negative offset makes it lead, by wrapping the delay modulo the period. New settings are taken up only at a reference period boundary.

Top module: `skew_clock_banks`

## Requirements
- R1: After reset, and until the first reference edge of the selected polarity has been sampled, every output is low.
- R2: `fs_i` sets the reference period in ticks: 2'b00 gives 32, 2'b01 gives 16, 2'b10 gives 8, and 2'b11 is read as 2'b01 (16).
- R3: Each select input encodes a level: 2'b00 is low, 2'b01 is mid, 2'b10 is high, and 2'b11 is read as mid. The setting index is 3*level(sel_hi_i)+level(sel_lo_i), with low=0, mid=1, high=2.
- R4: Banks 0 and 1 apply an offset of (index-4) tU.
- R5: Bank 2 applies 2*(index-4) tU for indices 1 to 7. Index 0 divides the reference by two: the output equals bit 0 of the count of aligned edges since lock, and the first edge counts as one. Index 8 divides by four: the output equals bit 1 of that count.
- R6: Bank 3 follows bank 2, except that index 8 gives the zero-offset output inverted.
- R7: At zero offset an output equals the reference value sampled on the same tick.
- R8: When `edge_sel_i` is 1, phase zero is the sampled rising edge of the reference; when it is 0, phase zero is the falling edge. Undivided outputs keep the reference polarity. Divided outputs change at phase zero.
- R9: With period P, an offset s gives delay s when s >= 0 and delay P+s when s < 0. The output at phase p is the zero-offset output at phase (p - delay) mod P.
- R10: A change of select inputs takes effect on the first tick whose phase is zero after the change. Until that tick the bank keeps its previous setting.
- R11: The two outputs of a bank are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, one period per tU |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Reference clock, sampled on each tick |
| edge_sel_i | input | 1 | 1 aligns to rising reference edges, 0 to falling |
| fs_i | input | 2 | Frequency select, sets the period in tU |
| sel_hi_i | input | NUM_BANKS x 2 | Upper three-level select, one per bank |
| sel_lo_i | input | NUM_BANKS x 2 | Lower three-level select, one per bank |
| q0_o | output | NUM_BANKS | First output of each bank |
| q1_o | output | NUM_BANKS | Second output of each bank |

## Verification
The assertions assume three things: the reference has a steady period equal to the selected tU count, `fs_i` and `edge_sel_i` change only while the block is held in reset, and an aligned edge never lands mid-period. Under those conditions the phase counter stays within the period and the lock never drops. The stimulus keeps to these assumptions. It generates the reference arithmetically from a tick index with exactly the selected period, and it applies a fresh reset before every change of frequency or edge polarity. It changes select codes only while running, in the dedicated boundary test.

// File: rtl/skew_bank_pkg.sv
package skew_bank_pkg;

  localparam int SKEW_W = 4;

  typedef enum logic [1:0] {
    MODE_SKEW,
    MODE_DIV2,
    MODE_DIV4,
    MODE_INV
  } mode_kind_e;

  typedef enum logic [1:0] {
    BANK_FINE,
    BANK_DIV,
    BANK_INV
  } bank_kind_e;

  typedef struct packed {
    mode_kind_e               kind;
    logic signed [SKEW_W-1:0] skew;
  } bank_mode_t;

  localparam bank_mode_t MODE_RESET = '{kind: MODE_SKEW, skew: '0};

  function automatic logic [1:0] level_of(logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b10:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic bank_kind_e kind_of_bank(int idx);
    if (idx < 2) return BANK_FINE;
    if (idx == 2) return BANK_DIV;
    return BANK_INV;
  endfunction

  function automatic bank_mode_t decode_mode(bank_kind_e bk, logic [1:0] hi, logic [1:0] lo);
    bank_mode_t       m;
    logic [3:0]       idx;
    logic signed [4:0] rel;
    idx    = 4'(level_of(hi)) * 4'd3 + 4'(level_of(lo));
    rel    = $signed({1'b0, idx}) - 5'sd4;
    m.kind = MODE_SKEW;
    m.skew = '0;
    if (bk == BANK_FINE) begin
      m.skew = rel[3:0];
    end else if (idx == 4'd0) begin
      m.kind = MODE_DIV2;
    end else if (idx == 4'd8) begin
      if (bk == BANK_DIV) m.kind = MODE_DIV4;
      else                m.kind = MODE_INV;
    end else begin
      m.skew = {rel[2:0], 1'b0};
    end
    return m;
  endfunction

endpackage

// File: rtl/skew_timebase.sv
module skew_timebase
  import skew_bank_pkg::*;
#(
  parameter  int BASE_TU    = 8,
  localparam int PERIOD_MAX = BASE_TU * 4,
  localparam int PW         = $clog2(PERIOD_MAX),
  localparam int LW         = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_i,
  input  logic          edge_sel_i,
  input  logic [1:0]    fs_i,
  output logic [LW-1:0] period_o,
  output logic [PW-1:0] phase_n_o,
  output logic          locked_n_o,
  output logic          bound_n_o
);

  logic          ref_q;
  logic          locked_q;
  logic [PW-1:0] phase_q;
  logic          edge_hit;
  logic          wrap;

  always_comb begin
    case (fs_i)
      2'b00:   period_o = LW'(PERIOD_MAX);
      2'b10:   period_o = LW'(BASE_TU);
      default: period_o = LW'(BASE_TU * 2);
    endcase
  end

  assign edge_hit = edge_sel_i ? (ref_i & ~ref_q) : (~ref_i & ref_q);
  assign wrap     = locked_q && ({1'b0, phase_q} == period_o - LW'(1));

  always_comb begin
    if (edge_hit)                phase_n_o = '0;
    else if (locked_q && !wrap)  phase_n_o = phase_q + 1'b1;
    else                         phase_n_o = '0;
  end

  assign locked_n_o = locked_q | edge_hit;
  assign bound_n_o  = edge_hit | wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q    <= 1'b0;
      locked_q <= 1'b0;
      phase_q  <= '0;
    end else begin
      ref_q    <= ref_i;
      locked_q <= locked_n_o;
      phase_q  <= phase_n_o;
    end
  end

  // R1: lock is never lost once gained
  a_r1_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);

  // R2: phase stays inside the selected period
  a_r2_phase_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> ({1'b0, phase_q} < period_o));

endmodule

// File: rtl/skew_bank.sv
module skew_bank
  import skew_bank_pkg::*;
#(
  parameter  bank_kind_e BANK_KIND  = BANK_FINE,
  parameter  int         BASE_TU    = 8,
  localparam int         PERIOD_MAX = BASE_TU * 4,
  localparam int         PW         = $clog2(PERIOD_MAX),
  localparam int         LW         = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_hi_i,
  input  logic [1:0]    sel_lo_i,
  input  logic          edge_sel_i,
  input  logic [LW-1:0] period_i,
  input  logic [PW-1:0] phase_n_i,
  input  logic          locked_n_i,
  input  logic          bound_n_i,
  output logic          q_o
);

  bank_mode_t        mode_q, mode_n, mode_dec;
  logic [1:0]        div_q, div_n;
  logic              out_q, out_n;
  logic              neg;
  logic [SKEW_W-1:0] mag;
  logic [LW-1:0]     delay, ph, rel;
  logic              base;

  assign mode_dec = decode_mode(BANK_KIND, sel_hi_i, sel_lo_i);
  assign mode_n   = bound_n_i ? mode_dec : mode_q;
  assign div_n    = div_q + (bound_n_i ? 2'd1 : 2'd0);

  // negative offsets wrap to a delay of period minus magnitude
  assign neg   = mode_n.skew[SKEW_W-1];
  assign mag   = neg ? (~mode_n.skew + 1'b1) : mode_n.skew;
  assign delay = neg ? (period_i - LW'(mag)) : LW'(mag);
  assign ph    = {1'b0, phase_n_i};
  assign rel   = (ph >= delay) ? (ph - delay) : (ph + period_i - delay);
  assign base  = (rel < (period_i >> 1)) ^ ~edge_sel_i;

  always_comb begin
    out_n = 1'b0;
    if (locked_n_i) begin
      case (mode_n.kind)
        MODE_DIV2: out_n = div_n[0];
        MODE_DIV4: out_n = div_n[1];
        MODE_INV:  out_n = ~base;
        default:   out_n = base;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RESET;
      div_q  <= '0;
      out_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      div_q  <= div_n;
      out_q  <= out_n;
    end
  end

  assign q_o = out_q;

  // R10: setting only moves on a period boundary
  a_r10_mode_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_n_i |=> $stable(mode_q));

  // R5: divide counter only steps on a period boundary
  a_r5_div_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bound_n_i |=> $stable(div_q));

  // R9: wrapped delay always falls inside the period
  a_r9_delay_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_n_i |-> (delay < period_i));

endmodule

// File: rtl/skew_clock_banks.sv
module skew_clock_banks
  import skew_bank_pkg::*;
#(
  parameter  int NUM_BANKS  = 4,
  parameter  int BASE_TU    = 8,
  localparam int PERIOD_MAX = BASE_TU * 4,
  localparam int PW         = $clog2(PERIOD_MAX),
  localparam int LW         = PW + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ref_i,
  input  logic                      edge_sel_i,
  input  logic [1:0]                fs_i,
  input  logic [NUM_BANKS-1:0][1:0] sel_hi_i,
  input  logic [NUM_BANKS-1:0][1:0] sel_lo_i,
  output logic [NUM_BANKS-1:0]      q0_o,
  output logic [NUM_BANKS-1:0]      q1_o
);

  logic [LW-1:0]        period;
  logic [PW-1:0]        phase_n;
  logic                 locked_n;
  logic                 bound_n;
  logic [NUM_BANKS-1:0] bank_q;

  skew_timebase #(.BASE_TU(BASE_TU)) u_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_i      (ref_i),
    .edge_sel_i (edge_sel_i),
    .fs_i       (fs_i),
    .period_o   (period),
    .phase_n_o  (phase_n),
    .locked_n_o (locked_n),
    .bound_n_o  (bound_n)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    skew_bank #(
      .BANK_KIND (kind_of_bank(b)),
      .BASE_TU   (BASE_TU)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_hi_i   (sel_hi_i[b]),
      .sel_lo_i   (sel_lo_i[b]),
      .edge_sel_i (edge_sel_i),
      .period_i   (period),
      .phase_n_i  (phase_n),
      .locked_n_i (locked_n),
      .bound_n_i  (bound_n),
      .q_o        (bank_q[b])
    );
  end

  assign q0_o = bank_q;
  assign q1_o = bank_q;

endmodule

// File: tb/skew_clock_banks_tb.sv
module skew_clock_banks_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int T0         = 3;

  logic                clk = 1'b0;
  logic                rst_ni;
  logic                ref_i;
  logic                edge_sel_i;
  logic [1:0]          fs_i;
  logic [NB-1:0][1:0]  sel_hi_i, sel_lo_i;
  logic [NB-1:0][1:0]  new_hi, new_lo;
  logic [NB-1:0]       q0_o, q1_o;

  int n_chk = 0;
  int n_bad = 0;
  int applied [NB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  skew_clock_banks u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ref_i      (ref_i),
    .edge_sel_i (edge_sel_i),
    .fs_i       (fs_i),
    .sel_hi_i   (sel_hi_i),
    .sel_lo_i   (sel_lo_i),
    .q0_o       (q0_o),
    .q1_o       (q1_o)
  );

  function automatic int lvl(logic [1:0] c);
    if (c == 2'b00) return 0;
    if (c == 2'b10) return 2;
    return 1;
  endfunction

  function automatic logic [1:0] enc(int l);
    if (l == 0) return 2'b00;
    if (l == 2) return 2'b10;
    return 2'b01;
  endfunction

  function automatic int period_of(logic [1:0] f);
    if (f == 2'b00) return 32;
    if (f == 2'b10) return 8;
    return 16;
  endfunction

  function automatic bit exp_out(int b, int idx, int phase, int k, int p, bit pe);
    int  skew, d, rel;
    bit  inv, base;
    inv  = 1'b0;
    skew = 0;
    if (b < 2) skew = idx - 4;
    else if (idx == 0) return k[0];
    else if (idx == 8) begin
      if (b == 2) return k[1];
      inv = 1'b1;
    end else skew = 2 * (idx - 4);
    d    = (skew >= 0) ? skew : p + skew;
    rel  = (phase - d + p) % p;
    base = (rel < p / 2) ^ !pe;
    return inv ? !base : base;
  endfunction

  task automatic chk(bit act, bit expv, string tag, int t, int b);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s bank %0d tick %0d: actual %b expected %b", tag, b, t, act, expv);
    end
  endtask

  task automatic run(logic [1:0] fs, bit pe, int n, int chg_at, string tag);
    int p, e0, phase, k;
    bit e;
    string btag;
    p          = period_of(fs);
    e0         = pe ? T0 : T0 + p / 2;
    rst_ni     = 1'b0;
    ref_i      = 1'b0;
    fs_i       = fs;
    edge_sel_i = pe;
    repeat (2) @(negedge clk);
    for (int b = 0; b < NB; b++) chk(q0_o[b], 1'b0, "R1 reset", -1, b);
    rst_ni = 1'b1;
    for (int t = 0; t < n; t++) begin
      if (t == chg_at) begin
        sel_hi_i = new_hi;
        sel_lo_i = new_lo;
      end
      ref_i = (t >= T0) && (((t - T0) % p) < p / 2);
      @(posedge clk);
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin
        btag = (b < 2) ? "R4" : ((b == 2) ? "R5" : "R6");
        if (t < e0) begin
          e = 1'b0;
          btag = "R1";
        end else begin
          phase = (t - e0) % p;
          k     = (t - e0) / p + 1;
          if (phase == 0) applied[b] = 3 * lvl(sel_hi_i[b]) + lvl(sel_lo_i[b]);
          e = exp_out(b, applied[b], phase, k, p, pe);
        end
        chk(q0_o[b], e, {tag, " ", btag}, t, b);
        chk(q1_o[b], e, {tag, " R11"}, t, b);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..R11 run hung: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] fsl [3];
    int p;
    fsl[0] = 2'b00; fsl[1] = 2'b01; fsl[2] = 2'b10;
    for (int b = 0; b < NB; b++) applied[b] = 4;
    sel_hi_i = '0; sel_lo_i = '0; new_hi = '0; new_lo = '0;
    rst_ni = 1'b0; ref_i = 1'b0; edge_sel_i = 1'b1; fs_i = 2'b01;

    // sweep R2 R3 R4 R5 R6 R7 R8 R9 over all settings, periods and polarities
    for (int f = 0; f < 3; f++) begin
      for (int pe = 0; pe < 2; pe++) begin
        for (int idx = 0; idx < 9; idx++) begin
          for (int b = 0; b < NB; b++) begin
            sel_hi_i[b] = enc(idx / 3);
            sel_lo_i[b] = enc(idx % 3);
          end
          p = period_of(fsl[f]);
          run(fsl[f], pe[0], T0 + p / 2 + 5 * p, -1, "R2 R7 R8 R9");
        end
      end
    end

    // R3 R2: unused code 2'b11 reads as mid on selects and on fs_i
    sel_hi_i[0] = 2'b11; sel_lo_i[0] = 2'b00;
    sel_hi_i[1] = 2'b11; sel_lo_i[1] = 2'b11;
    sel_hi_i[2] = 2'b10; sel_lo_i[2] = 2'b11;
    sel_hi_i[3] = 2'b00; sel_lo_i[3] = 2'b11;
    run(2'b11, 1'b1, T0 + 5 * 16, -1, "R3 R2");
    run(2'b11, 1'b0, T0 + 8 + 5 * 16, -1, "R3 R2");

    // R10: change mid-period, takes effect at next boundary
    for (int b = 0; b < NB; b++) begin
      sel_hi_i[b] = 2'b01; sel_lo_i[b] = 2'b01;
      new_hi[b]   = 2'b10; new_lo[b]   = 2'b10;
    end
    run(2'b10, 1'b1, T0 + 6 * 8, T0 + 8 + 3, "R10");
    for (int b = 0; b < NB; b++) begin
      sel_hi_i[b] = 2'b00; sel_lo_i[b] = 2'b10;
      new_hi[b]   = 2'b00; new_lo[b]   = 2'b00;
    end
    run(2'b01, 1'b0, T0 + 8 + 6 * 16, T0 + 8 + 16 + 5, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule